// File: doc/BRIEF.md
# Variable-Latency Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor as signed or unsigned integers. It returns a quotient and an overflow flag. The time it takes depends on the operands. A one-cycle `start_i` pulse captures the operands and the mode. Some cycles later, `done_o` rises for a single cycle, and the quotient and flag are valid in that cycle.

Each operand is given a size. The size counts the operand's significant bits two at a time. Bit positions 0 and 1 give size 1, positions 2 and 3 give size 2, and so on; zero has size 0. In signed mode a negative operand is made positive before it is measured.

The busy time follows from the difference between the two sizes, plus a fixed base that is larger for signed mode. Inside that window a restoring divider produces two quotient bits per cycle. It starts at the highest bit position where the shifted divisor can still fit, so it finishes before the window ends. Division by zero, and the signed case of the most negative value divided by -1, raise the overflow flag and leave the visible quotient unchanged.

Top module: `varlat_div`

## Requirements
- R1: The size of a nonzero operand is floor(i/2)+1, where i is the index of its highest set bit; an operand of zero has size 0. Bits 0 and 1 therefore share size 1, bits 2 and 3 share size 2, and so on.
- R2: In signed mode (`signed_i`=1), an operand with bit 31 set is negated before its size is taken.
- R3: Unsigned latency, for a nonzero divisor, is 2 cycles when the dividend size is below the divisor size, and 3 plus (dividend size minus divisor size) otherwise.
- R4: Signed latency, for a non-overflow case, is 3 cycles when the dividend size is below the divisor size, and 5 plus the size difference otherwise.
- R5: A zero divisor ends with `ovf_o`=1 after 2 cycles when unsigned and 3 cycles when signed. `quot_o` keeps the last quotient that was written.
- R6: A division that does not overflow ends with `ovf_o`=0 and `quot_o` equal to the truncated quotient. That value is still shown on `quot_o` after `done_o` falls.
- R7: A signed quotient truncates toward zero, and its sign is the XOR of the operand signs.
- R8: In signed mode, 0x80000000 divided by 0xFFFFFFFF is an overflow: `ovf_o`=1, latency 3, and the quotient is not written.
- R9: Latency is counted from the cycle after the one in which `start_i` is taken (that cycle is cycle 1). `busy_o` is high from cycle 1 through cycle L. `done_o` is high only in cycle L. Both are low in cycle L+1.
- R10: `start_i` has no effect while `busy_o` is high. The running operation keeps its latency, flag and quotient.
- R11: After reset, `busy_o`, `done_o`, `ovf_o` are 0 and `quot_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division; taken only when idle |
| signed_i | input | 1 | 1 = signed operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend, sampled with start |
| divisor_i | input | 32 | Divisor, sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Quotient; holds the last written value |
| ovf_o | output | 1 | Overflow (zero divisor or signed overflow) |

## Verification
The assertions check several rules on every cycle:
- `done_o` never lasts two cycles.
- `busy_o` cannot drop before `done_o`.
- A latency that is taken always falls inside the signed or unsigned bounds.
- The quotient engine is idle by the time `done_o` rises, with a remainder below the divisor.
- An overflow never changes the visible quotient.
- A start request while busy never disturbs the flag.

Only the bench's scenarios can show the exact cycle counts. Those cover pair-boundary operands, negated signed operands, the zero and signed-overflow cases, and a request ignored mid-run. The bench also checks the quotient values and rounding toward zero.

// File: rtl/vld_pkg.sv
package vld_pkg;
  localparam int unsigned PAIR    = 2;
  localparam int unsigned U_SHORT = 2;
  localparam int unsigned U_BASE  = 3;
  localparam int unsigned U_ZERO  = 2;
  localparam int unsigned S_SHORT = 3;
  localparam int unsigned S_BASE  = 5;
  localparam int unsigned S_ZERO  = 3;
endpackage

// File: rtl/vld_size.sv
module vld_size #(
  parameter int unsigned W   = 32,
  parameter int unsigned SZW = 5
) (
  input  logic [W-1:0]   val_i,
  input  logic           signed_i,
  output logic [W-1:0]   mag_o,
  output logic [SZW-1:0] size_o,
  output logic           neg_o
);
  always_comb begin
    neg_o  = signed_i & val_i[W-1];
    mag_o  = neg_o ? (~val_i + 1'b1) : val_i;
    size_o = '0;
    // highest set bit wins, grouped two positions per step
    for (int i = 0; i < int'(W); i++)
      if (mag_o[i]) size_o = SZW'((i + 2) / 2);
  end
endmodule

// File: rtl/vld_latency.sv
module vld_latency
  import vld_pkg::*;
#(
  parameter int unsigned SZW  = 5,
  parameter int unsigned LATW = 5
) (
  input  logic [SZW-1:0]  nb_i,
  input  logic [SZW-1:0]  db_i,
  input  logic            signed_i,
  input  logic            ovf_i,
  output logic [LATW-1:0] lat_o
);
  logic [SZW-1:0] diff;

  always_comb begin
    diff = nb_i - db_i;
    if (ovf_i)
      lat_o = signed_i ? LATW'(S_ZERO) : LATW'(U_ZERO);
    else if (nb_i < db_i)
      lat_o = signed_i ? LATW'(S_SHORT) : LATW'(U_SHORT);
    else
      lat_o = (signed_i ? LATW'(S_BASE) : LATW'(U_BASE)) + LATW'(diff);
  end
endmodule

// File: rtl/vld_core.sv
module vld_core
  import vld_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned SZW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           go_i,
  input  logic [W-1:0]   rem_i,
  input  logic [W-1:0]   dvs_i,
  input  logic [SZW-1:0] pair_i,
  output logic           active_o,
  output logic [W-1:0]   quot_o
);
  localparam int unsigned BW = $clog2(W);

  logic [W-1:0]   rem_q, dvs_q, q_q, rem_n, q_n;
  logic [SZW-1:0] pair_q;
  logic           act_q;

  // two restoring steps per cycle, top bit of the pair first
  always_comb begin
    logic [2*W-1:0] trial;
    logic [BW-1:0]  bitpos;
    rem_n = rem_q;
    q_n   = q_q;
    for (int k = 0; k < int'(PAIR); k++) begin
      bitpos = BW'(int'(PAIR) * int'(pair_q) + int'(PAIR) - 1 - k);
      trial  = {{W{1'b0}}, dvs_q} << bitpos;
      if ({{W{1'b0}}, rem_n} >= trial) begin
        rem_n     = rem_n - trial[W-1:0];
        q_n[bitpos] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      q_q    <= '0;
      pair_q <= '0;
      act_q  <= 1'b0;
    end else if (load_i) begin
      rem_q  <= rem_i;
      dvs_q  <= dvs_i;
      q_q    <= '0;
      pair_q <= pair_i;
      act_q  <= go_i;
    end else if (act_q) begin
      rem_q <= rem_n;
      q_q   <= q_n;
      if (pair_q == '0) act_q <= 1'b0;
      else              pair_q <= pair_q - 1'b1;
    end
  end

  assign active_o = act_q;
  assign quot_o   = q_q;

  // R6: finished remainder is below the divisor
  assert_rem_below_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && $fell(act_q)) |-> (rem_q < dvs_q));
endmodule

// File: rtl/varlat_div.sv
module varlat_div
  import vld_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic         ovf_o
);
  localparam int unsigned NSZ  = W / PAIR;
  localparam int unsigned SZW  = $clog2(NSZ + 1);
  localparam int unsigned LATW = $clog2(S_BASE + NSZ + 2);
  localparam int unsigned LMIN = U_SHORT;
  localparam int unsigned LMAX = S_BASE + NSZ;

  logic [W-1:0]   opnd [2];
  logic [W-1:0]   mag  [2];
  logic [SZW-1:0] sz   [2];
  logic           neg  [2];

  assign opnd[0] = dividend_i;
  assign opnd[1] = divisor_i;

  for (genvar g = 0; g < 2; g++) begin : g_size
    vld_size #(.W(W), .SZW(SZW)) u_size (
      .val_i    (opnd[g]),
      .signed_i (signed_i),
      .mag_o    (mag[g]),
      .size_o   (sz[g]),
      .neg_o    (neg[g])
    );
  end

  logic accept, div_zero, min_neg1, ovf_d;
  logic [LATW-1:0] lat_d;

  assign div_zero = (divisor_i == '0);
  assign min_neg1 = signed_i && (dividend_i == {1'b1, {(W-1){1'b0}}}) && (&divisor_i);
  assign ovf_d    = div_zero | min_neg1;

  vld_latency #(.SZW(SZW), .LATW(LATW)) u_lat (
    .nb_i     (sz[0]),
    .db_i     (sz[1]),
    .signed_i (signed_i),
    .ovf_i    (ovf_d),
    .lat_o    (lat_d)
  );

  logic           busy_q, ovf_q, neg_q, done;
  logic [LATW-1:0] cnt_q;
  logic [W-1:0]   last_q, core_q, res;
  logic           core_act;

  assign accept = start_i & ~busy_q;
  assign done   = busy_q && (cnt_q == LATW'(1));

  vld_core #(.W(W), .SZW(SZW)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .go_i     (~ovf_d & (sz[0] >= sz[1])),
    .rem_i    (mag[0]),
    .dvs_i    (mag[1]),
    .pair_i   (sz[0] - sz[1]),
    .active_o (core_act),
    .quot_o   (core_q)
  );

  assign res = neg_q ? (~core_q + 1'b1) : core_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      neg_q  <= 1'b0;
      last_q <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= lat_d;
        ovf_q  <= ovf_d;
        neg_q  <= neg[0] ^ neg[1];
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (done) busy_q <= 1'b0;
      end
      if (done && !ovf_q) last_q <= res;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done;
  assign ovf_o  = ovf_q;
  assign quot_o = (done && !ovf_q) ? res : last_q;

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R3 and R4 bounds
  assert_lat_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (lat_d >= LATW'(LMIN) && lat_d <= LATW'(LMAX)));
  assert_core_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !core_act);
  assert_ovf_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovf_o) |=> (quot_o == $past(quot_o)));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (ovf_o == $past(ovf_o)));
endmodule

// File: tb/varlat_div_test.sv
module varlat_div_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sgn = 1'b0;
  logic [31:0] dvd = '0, dvs = '0;
  logic        busy, done, ovf;
  logic [31:0] quot;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_q = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  varlat_div uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dividend_i(dvd), .divisor_i(dvs), .busy_o(busy), .done_o(done),
    .quot_o(quot), .ovf_o(ovf)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int size_of(input logic [31:0] v, input bit s);
    logic [31:0] m;
    m = (s && v[31]) ? (32'd0 - v) : v;
    for (int i = 31; i >= 0; i--)
      if (m[i]) return i / 2 + 1;
    return 0;
  endfunction

  // one division; poke>0 raises start with junk operands in that cycle
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit s,
                        input int poke, input string tag);
    int nb, db, lat, k;
    bit zero, ov;
    logic [31:0] q;
    nb = size_of(a, s);
    db = size_of(b, s);
    zero = (b == 0);
    ov = zero || (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
    if (ov) lat = s ? 3 : 2;
    else if (nb < db) lat = s ? 3 : 2;
    else lat = (s ? 5 : 3) + nb - db;
    if (ov) q = model_q;
    else if (s) q = 32'($signed(a) / $signed(b));
    else q = a / b;
    @(negedge clk);
    dvd = a; dvs = b; sgn = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 40) begin
      check(busy == 1'b1, {tag, " R9 busy"}, busy, 1);
      if (k == poke) begin
        dvd = 32'h0000_0001; dvs = 32'h0; sgn = ~s; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(k == lat, {tag, " latency R3 R4 R5"}, k, lat);
    check(ovf == ov, {tag, " ovf R5 R6 R8"}, ovf, ov);
    check(quot == q, {tag, " quot R6 R7"}, quot, q);
    @(negedge clk);
    check(!done && !busy, {tag, " R9 done pulse"}, {done, busy}, 0);
    check(quot == q, {tag, " R6 hold"}, quot, q);
    model_q = q;
  endtask

  task automatic t_reset();
    check(!busy && !done && !ovf && quot == 0, "R11 reset", {busy, done, ovf, quot}, 0);
  endtask

  task automatic t_unsigned();
    run_op(32'd100, 32'd7, 0, 0, "R3 u100/7");
    run_op(32'd5, 32'd100, 0, 0, "R3 u short");
    run_op(32'hFFFF_FFFF, 32'd1, 0, 0, "R3 u max");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R3 u equal");
  endtask

  task automatic t_pairs();
    run_op(32'd3, 32'd2, 0, 0, "R1 pair 3/2");
    run_op(32'd4, 32'd2, 0, 0, "R1 pair 4/2");
    run_op(32'd1, 32'd1, 0, 0, "R1 pair 1/1");
    run_op(32'd0, 32'd9, 0, 0, "R1 zero dividend");
  endtask

  task automatic t_signed();
    run_op(-32'sd100, 32'd7, 1, 0, "R2 R7 s-100/7");
    run_op(32'd100, -32'sd7, 1, 0, "R2 R7 s100/-7");
    run_op(-32'sd7, -32'sd100, 1, 0, "R4 s short");
    run_op(32'h8000_0000, 32'd1, 1, 0, "R4 s min/1");
    run_op(-32'sd1, 32'd1, 1, 0, "R7 s-1/1");
    run_op(-32'sd9, 32'd2, 1, 0, "R7 trunc");
  endtask

  task automatic t_overflow();
    run_op(32'd1234, 32'd55, 0, 0, "R6 prime");
    run_op(32'd77, 32'd0, 0, 0, "R5 u zero");
    run_op(-32'sd77, 32'd0, 1, 0, "R5 s zero");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, "R8 min/-1");
  endtask

  task automatic t_ignore();
    run_op(32'hFFFF_FFFF, 32'd1, 0, 3, "R10 ignore");
    run_op(32'd1000, 32'd3, 1, 2, "R10 ignore s");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_pairs();
    t_signed();
    t_overflow();
    t_ignore();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=0 exp=1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule